// File: doc/BRIEF.md
# Programmable Address Window Router

This block examines every address a processor issues and sends it to one of two downstream ports. One is the memory-controller port. The other is the general interconnect port. The split is set by a window with a lower bound and an upper bound, both held in registers that a small write interface loads.

Any address inside the window, bounds included, goes to memory. Every other address goes to the interconnect. The window works in whole megabytes. The lower bound's sub-megabyte bits are treated as zeros, and the upper bound's as ones. The upper bound is clamped into a fixed legal span.

Above the window, and below a fixed 64 MB peripheral window at the top of the space, lies a variable-sized aperture for programmable-logic slaves. Below the window lies the low boot area, which can be folded into memory by programming a zero lower bound. Next to the route, the block reports a region tag for each address.

Top module: `addr_window_router`

## Requirements
- R1: After reset the lower bound is 0x0010_0000 and the upper bound is 0xBFFF_FFFF. `outValid`, `routeMem` and `routeIc` are low.
- R2: An address A with lower ≤ A ≤ upper goes to memory: `routeMem`=1, `routeIc`=0 and `regionTag`=1.
- R3: An address outside the window goes to the interconnect: `routeIc`=1 and `routeMem`=0.
- R4: With the reset lower bound, addresses 0x0 to 0xF_FFFF go to the interconnect with `regionTag`=0 (boot). Any interconnect-bound address below the lower bound also gets tag 0.
- R5: Writing a lower bound of 0x0 sends 0x0 to 0xF_FFFF to memory with tag 1.
- R6: Bounds have 1 MB granularity. Bits [19:0] of `cfgData` are ignored. The lower bound takes them as zeros and the upper bound as ones.
- R7: A written upper bound below 0xBFFF_FFFF is clamped to 0xBFFF_FFFF. One above 0xFBFF_FFFF is clamped to 0xFBFF_FFFF.
- R8: Addresses from upper+1 to 0xFBFF_FFFF go to the interconnect with `regionTag`=2. This aperture is empty when the upper bound is 0xFBFF_FFFF.
- R9: Addresses 0xFC00_0000 to 0xFFFF_FFFF always go to the interconnect with `regionTag`=3, whatever the bounds.
- R10: Route outputs and tag appear on the clock edge after the edge that samples `addrValid`=1. Exactly one route is high while `outValid`=1. Both routes are low while `outValid`=0.
- R11: A write with `cfgWrEn`=1 loads the lower bound when `cfgSel`=0 and the upper bound when `cfgSel`=1. An address sampled on the same edge as the write still uses the old bounds. An address sampled on the next edge uses the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Bound register write strobe |
| cfgSel | input | 1 | 0 selects lower bound, 1 selects upper bound |
| cfgData | input | 32 | Bound value written |
| addrValid | input | 1 | Address qualifier |
| addr | input | 32 | Processor address |
| outValid | output | 1 | Registered result valid |
| routeMem | output | 1 | Address routed to memory port |
| routeIc | output | 1 | Address routed to interconnect port |
| regionTag | output | 2 | 0 boot, 1 memory, 2 logic-slave aperture, 3 peripheral |

## Verification
The hardest situation to reach is a boundary that only exists for a non-default bound pair. Examples are the last byte below a raised lower bound, an inverted window where lower exceeds upper, and the aperture vanishing at the maximum upper bound. The stimulus programs several bound pairs, including clamped and unaligned writes. For each pair it sweeps every megabyte of the 4 GB space at both its first and last byte. A separate sequence issues a write and an address on the same edge to expose the one-edge update timing.

// File: rtl/awr_pkg.sv
package awr_pkg;
  localparam int ADDR_W     = 32;
  localparam int GRAN_SHIFT = 20;
  localparam int MB_BITS    = ADDR_W - GRAN_SHIFT;

  typedef enum logic [1:0] {
    TAG_BOOT   = 2'd0,
    TAG_MEM    = 2'd1,
    TAG_FPGA   = 2'd2,
    TAG_PERIPH = 2'd3
  } regionTag_t;

  typedef struct packed {
    logic               loadStart;
    logic               loadEnd;
    logic               sample;
    logic [MB_BITS-1:0] boundMb;
  } cfgStrobe_t;
endpackage

// File: rtl/awr_ctrl.sv
module awr_ctrl
  import awr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] END_LO = 32'hBFFF_FFFF,
  parameter logic [ADDR_W-1:0] END_HI = 32'hFBFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              addrValid,
  output cfgStrobe_t        strobe
);
  localparam logic [MB_BITS-1:0] END_LO_MB = END_LO[ADDR_W-1:GRAN_SHIFT];
  localparam logic [MB_BITS-1:0] END_HI_MB = END_HI[ADDR_W-1:GRAN_SHIFT];

  logic [MB_BITS-1:0] dataMb;
  logic [MB_BITS-1:0] endClampedMb;
  logic               unusedLowBits;

  assign dataMb        = cfgData[ADDR_W-1:GRAN_SHIFT];
  assign unusedLowBits = ^cfgData[GRAN_SHIFT-1:0];

  always_comb begin
    if (dataMb < END_LO_MB)      endClampedMb = END_LO_MB;
    else if (dataMb > END_HI_MB) endClampedMb = END_HI_MB;
    else                         endClampedMb = dataMb;
  end

  always_comb begin
    strobe.loadStart = cfgWrEn && !cfgSel;
    strobe.loadEnd   = cfgWrEn && cfgSel;
    strobe.sample    = addrValid;
    strobe.boundMb   = cfgSel ? endClampedMb : dataMb;
  end

  // R11: never load both bounds at once
  p_single_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.loadStart, strobe.loadEnd}));

  // R7: an upper-bound load never carries an illegal value
  p_end_clamped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadEnd |-> (strobe.boundMb >= END_LO_MB && strobe.boundMb <= END_HI_MB));
endmodule

// File: rtl/awr_dp.sv
module awr_dp
  import awr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] START_RST   = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] END_RST     = 32'hBFFF_FFFF,
  parameter logic [ADDR_W-1:0] END_LO      = 32'hBFFF_FFFF,
  parameter logic [ADDR_W-1:0] END_HI      = 32'hFBFF_FFFF,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 32'hFC00_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfgStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic              outValid,
  output logic              routeMem,
  output logic              routeIc,
  output regionTag_t        regionTag
);
  localparam logic [MB_BITS-1:0]    START_RST_MB = START_RST[ADDR_W-1:GRAN_SHIFT];
  localparam logic [MB_BITS-1:0]    END_RST_MB   = END_RST[ADDR_W-1:GRAN_SHIFT];
  localparam logic [MB_BITS-1:0]    END_LO_MB    = END_LO[ADDR_W-1:GRAN_SHIFT];
  localparam logic [MB_BITS-1:0]    END_HI_MB    = END_HI[ADDR_W-1:GRAN_SHIFT];
  localparam logic [GRAN_SHIFT-1:0] LOW_ONES     = '1;

  logic [MB_BITS-1:0] startMb;
  logic [MB_BITS-1:0] endMb;
  logic [ADDR_W-1:0]  startFull;
  logic [ADDR_W-1:0]  endFull;
  logic               inWindow;
  logic               inPeriph;
  logic               aboveEnd;
  regionTag_t         tagNext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startMb <= START_RST_MB;
      endMb   <= END_RST_MB;
    end else begin
      if (strobe.loadStart) startMb <= strobe.boundMb;
      if (strobe.loadEnd)   endMb   <= strobe.boundMb;
    end
  end

  assign startFull = {startMb, {GRAN_SHIFT{1'b0}}};
  assign endFull   = {endMb, LOW_ONES};
  assign inPeriph  = addr >= PERIPH_BASE;
  assign inWindow  = (addr >= startFull) && (addr <= endFull);
  assign aboveEnd  = addr > endFull;

  always_comb begin
    if (inPeriph)      tagNext = TAG_PERIPH;
    else if (inWindow) tagNext = TAG_MEM;
    else if (aboveEnd) tagNext = TAG_FPGA;
    else               tagNext = TAG_BOOT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      routeMem  <= 1'b0;
      routeIc   <= 1'b0;
      regionTag <= TAG_BOOT;
    end else begin
      outValid  <= strobe.sample;
      routeMem  <= strobe.sample && (tagNext == TAG_MEM);
      routeIc   <= strobe.sample && (tagNext != TAG_MEM);
      regionTag <= strobe.sample ? tagNext : TAG_BOOT;
    end
  end

  p_end_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    endMb >= END_LO_MB && endMb <= END_HI_MB);

  p_end_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadEnd |=> endMb == $past(strobe.boundMb));

  p_one_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $countones({routeMem, routeIc}) == 1);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> !routeMem && !routeIc);

  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.sample |=> outValid);

  p_mem_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (routeMem == (regionTag == TAG_MEM)));

  p_periph_ic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && regionTag == TAG_PERIPH) |-> routeIc);
endmodule

// File: rtl/addr_window_router.sv
module addr_window_router
  import awr_pkg::*;
#(
  parameter logic [31:0] START_RST   = 32'h0010_0000,
  parameter logic [31:0] END_RST     = 32'hBFFF_FFFF,
  parameter logic [31:0] END_LO      = 32'hBFFF_FFFF,
  parameter logic [31:0] END_HI      = 32'hFBFF_FFFF,
  parameter logic [31:0] PERIPH_BASE = 32'hFC00_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgWrEn,
  input  logic        cfgSel,
  input  logic [31:0] cfgData,
  input  logic        addrValid,
  input  logic [31:0] addr,
  output logic        outValid,
  output logic        routeMem,
  output logic        routeIc,
  output logic [1:0]  regionTag
);
  cfgStrobe_t strobe;
  regionTag_t tagOut;

  awr_ctrl #(
    .END_LO (END_LO),
    .END_HI (END_HI)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgData   (cfgData),
    .addrValid (addrValid),
    .strobe    (strobe)
  );

  awr_dp #(
    .START_RST   (START_RST),
    .END_RST     (END_RST),
    .END_LO      (END_LO),
    .END_HI      (END_HI),
    .PERIPH_BASE (PERIPH_BASE)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .addr      (addr),
    .outValid  (outValid),
    .routeMem  (routeMem),
    .routeIc   (routeIc),
    .regionTag (tagOut)
  );

  assign regionTag = tagOut;
endmodule

// File: tb/sim_addr_window_router.sv
`timescale 1ns/1ps
module sim_addr_window_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgData = '0;
  logic        addrValid = 1'b0;
  logic [31:0] addr = '0;
  logic        outValid, routeMem, routeIc;
  logic [1:0]  regionTag;

  int nVec = 0;
  int nBad = 0;
  logic [31:0] expStart = 32'h0010_0000;
  logic [31:0] expEnd   = 32'hBFFF_FFFF;

  always #4 clk = ~clk;

  addr_window_router u0 (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgData(cfgData), .addrValid(addrValid), .addr(addr),
    .outValid(outValid), .routeMem(routeMem), .routeIc(routeIc),
    .regionTag(regionTag)
  );

  function automatic logic [1:0] refTag(input logic [31:0] a);
    if (a >= 32'hFC00_0000)                return 2'd3;
    else if (a >= expStart && a <= expEnd) return 2'd1;
    else if (a > expEnd)                   return 2'd2;
    else                                   return 2'd0;
  endfunction

  function automatic string reqFor(input logic [1:0] t);
    case (t)
      2'd0: return "R4/R3";
      2'd1: return "R2";
      2'd2: return "R8/R3";
      default: return "R9";
    endcase
  endfunction

  task automatic checkOut(input string req, input logic [31:0] a, input logic v,
                          input logic [1:0] t);
    logic eMem, eIc;
    eMem = v && (t == 2'd1);
    eIc  = v && (t != 2'd1);
    nVec++;
    if (outValid !== v || routeMem !== eMem || routeIc !== eIc ||
        (v && regionTag !== t)) begin
      nBad++;
      $display("FAIL %s addr=%h actual v=%0b mem=%0b ic=%0b tag=%0d expected v=%0b mem=%0b ic=%0b tag=%0d",
               req, a, outValid, routeMem, routeIc, regionTag, v, eMem, eIc, t);
    end
  endtask

  task automatic vec(input logic [31:0] a, input logic v, input string req);
    logic [1:0] t;
    @(negedge clk);
    addr = a; addrValid = v;
    t = refTag(a);
    @(negedge clk);
    checkOut((req == "") ? reqFor(t) : req, a, v, t);
    addrValid = 1'b0;
  endtask

  // R6/R7 model: lower bound zeroes low bits, upper bound ones and clamps
  task automatic writeBound(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (!sel) expStart = {d[31:20], 20'h0};
    else begin
      expEnd = {d[31:20], 20'hFFFFF};
      if (expEnd < 32'hBFFF_FFFF) expEnd = 32'hBFFF_FFFF;
      if (expEnd > 32'hFBFF_FFFF) expEnd = 32'hFBFF_FFFF;
    end
  endtask

  task automatic sweep();
    for (int mb = 0; mb < 4096; mb++) begin
      vec({mb[11:0], 20'h00000}, 1'b1, "");
      vec({mb[11:0], 20'hFFFFF}, 1'b1, "");
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of outputs and bounds
    checkOut("R1", 32'h0, 1'b0, 2'd0);
    vec(32'h000F_FFFF, 1'b1, "R1");
    vec(32'h0010_0000, 1'b1, "R1");
    vec(32'hBFFF_FFFF, 1'b1, "R1");
    vec(32'hC000_0000, 1'b1, "R1");
    // R10: no route while address not valid
    vec(32'h2000_0000, 1'b0, "R10");

    // R11: write and address on the same edge, then next edge
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 1'b1; cfgData = 32'hC000_0000;
    addr = 32'hC00F_FFFF; addrValid = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    checkOut("R11", addr, 1'b1, 2'd2);
    expEnd = 32'hC00F_FFFF;
    @(negedge clk);
    checkOut("R11", addr, 1'b1, 2'd1);
    addrValid = 1'b0;
    // R11: cfgSel=0 loads lower bound
    writeBound(1'b0, 32'h0000_0000);
    vec(32'h0000_0000, 1'b1, "R5");
    vec(32'h000F_FFFF, 1'b1, "R5");

    // default bounds sweep
    writeBound(1'b0, 32'h0010_0000);
    writeBound(1'b1, 32'hBFFF_FFFF);
    sweep();
    // R5 plus R7 high clamp, empty aperture (R8)
    writeBound(1'b0, 32'h0000_0000);
    writeBound(1'b1, 32'hFFFF_FFFF);
    vec(32'hFBFF_FFFF, 1'b1, "R7");
    sweep();
    // R6: unaligned bounds
    writeBound(1'b0, 32'h0050_1234);
    writeBound(1'b1, 32'hC030_0000);
    vec(32'h004F_FFFF, 1'b1, "R6");
    vec(32'hC03F_FFFF, 1'b1, "R6");
    sweep();
    // R7: low clamp, raised lower bound
    writeBound(1'b0, 32'h0C00_0000);
    writeBound(1'b1, 32'h1234_5678);
    vec(32'hBFFF_FFFF, 1'b1, "R7");
    vec(32'hC000_0000, 1'b1, "R7");
    sweep();
    // inverted window: nothing reaches memory
    writeBound(1'b0, 32'hE000_0000);
    writeBound(1'b1, 32'hD00A_BCDE);
    sweep();

    summary();
    $finish;
  end
endmodule